// File: doc/BRIEF.md
# Configuration Port Key-Unlock Controller

This block sits behind a two-byte host I/O window of a multi-function peripheral chip. One byte of the window is the index port and the other is the data port. A register is reached by writing its index to the index port and then reading or writing the data port. The window stays locked after reset. While it is locked, every index-port write goes to a key detector, and data-port traffic has no effect.

The detector looks for a four-byte key written to the index port. The key is 0x87, then 0x01, then 0x55, then a final byte. The final byte is 0x55 when the strap input selects the primary base port and 0xAA when it selects the alternate base port. When the key completes, the block enters configuration mode. In that mode the window reaches a small global register file:

- a 16-bit chip identifier, split over two registers;
- a revision register;
- a logical-device select register;
- for each logical device, a stored 16-bit I/O base address held as a high and a low register.

Writing the exit code to the control register locks the window again.

Top module: `cfg_key_unlock`

## Requirements
- R1: After reset the block is locked (`cfg_mode_o` = 0), and both the index port and the data port read 0xFF.
- R2: With `strap_alt_i` = 0, the index-port writes 0x87, 0x01, 0x55, 0x55 set `cfg_mode_o` in the cycle after the fourth write.
- R3: With `strap_alt_i` = 1, the fourth key byte is 0xAA. The series 0x87, 0x01, 0x55, 0x55 does not unlock the block, and 0x87, 0x01, 0x55, 0xAA does.
- R4: A byte that does not match returns the detector to its idle state. If the non-matching byte is 0x87, it counts as the first key byte.
- R5: With the primary strap, 0xAA written as the fourth byte, or as a stray byte, does not unlock the block. A following complete key still unlocks it.
- R6: While locked, data-port reads return 0xFF. Data-port writes and non-key index writes change no register: neither the stored index nor the device select.
- R7: In configuration mode, index 0x20 reads the identifier high byte and index 0x21 reads the low byte. The defaults are 0xC0 and 0xDE. Writes to these indices are ignored.
- R8: Index 0x22 reads the revision in bits 3:0 with bits 7:4 zero, so the default reads 0x05. The register is read-only.
- R9: Index 0x07 holds the logical-device select and reads back what was written. Indices 0x60 and 0x61 read and write the high and low base-address bytes of the selected device. Each device keeps its own base address.
- R10: A data write of 0x02 at control index 0x02 leaves configuration mode on the next cycle. Any other value written there leaves the mode set. The control index reads 0x00.
- R11: In configuration mode, the index port reads back the stored index. When the device select is NUM_DEV or above, indices 0x60 and 0x61 read 0xFF and ignore writes.
- R12: Reset clears configuration mode and the device select back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_alt_i | input | 1 | Base-port strap: 0 = primary (final key byte 0x55), 1 = alternate (final key byte 0xAA) |
| wr_i | input | 1 | Host write strobe, one cycle per byte |
| addr_i | input | 1 | Window select: 0 = index port, 1 = data port |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for the port that `addr_i` selects |
| cfg_mode_o | output | 1 | High while configuration mode is active |

## Verification
The assertions assume that each host write is a single-cycle `wr_i` pulse. They also assume that `strap_alt_i` stays constant between resets, and the strap-dependent key check relies on this. The stimulus changes the strap only while reset is held, and it drives each write for exactly one clock, separated from the next by an idle cycle. Reads are side-effect free and combinational, so the stimulus applies the address and samples `rdata_o` in the same low clock phase, with no strobe.

// File: rtl/cfg_key_pkg.sv
package cfg_key_pkg;
  localparam logic [7:0] KEY_B0      = 8'h87;
  localparam logic [7:0] KEY_B1      = 8'h01;
  localparam logic [7:0] KEY_B2      = 8'h55;
  localparam logic [7:0] KEY_B3_PRI  = 8'h55;
  localparam logic [7:0] KEY_B3_ALT  = 8'hAA;
  localparam logic [7:0] EXIT_CODE   = 8'h02;
  localparam logic [7:0] IDX_CTRL    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] RD_LOCKED   = 8'hFF;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_GOT1,
    KS_GOT2,
    KS_GOT3
  } key_step_e;
endpackage

// File: rtl/cfg_key_detect.sv
module cfg_key_detect
  import cfg_key_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       alt_i,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       exit_i,
  output logic       mode_o
);
  key_step_e  step_q;
  logic       mode_q;
  logic [7:0] want;

  always_comb begin
    unique case (step_q)
      KS_IDLE: want = KEY_B0;
      KS_GOT1: want = KEY_B1;
      KS_GOT2: want = KEY_B2;
      default: want = alt_i ? KEY_B3_ALT : KEY_B3_PRI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= KS_IDLE;
      mode_q <= 1'b0;
    end else if (mode_q) begin
      step_q <= KS_IDLE;
      if (exit_i) mode_q <= 1'b0;
    end else if (idx_wr_i) begin
      if (wdata_i == want) begin
        if (step_q == KS_GOT3) begin
          mode_q <= 1'b1;
          step_q <= KS_IDLE;
        end else begin
          step_q <= key_step_e'(step_q + 2'd1);
        end
      end else begin
        // a mismatching first key byte restarts the match
        step_q <= (wdata_i == KEY_B0) ? KS_GOT1 : KS_IDLE;
      end
    end
  end

  assign mode_o = mode_q;

  // R2
  enter_on_idx_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q) |-> $past(idx_wr_i));

  // R10
  exit_on_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode_q) |-> $past(exit_i));

  // R4
  idle_in_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_q) && mode_q |-> step_q == KS_IDLE);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_key_pkg::*;
#(
  parameter int          NUM_DEV  = 4,
  parameter logic [15:0] CHIP_ID  = 16'hC0DE,
  parameter logic [3:0]  CHIP_REV = 4'h5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_i,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       exit_o
);
  localparam int         DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [7:0] DEV_LIM = 8'(NUM_DEV);

  logic [7:0]  index_q;
  logic [7:0]  ldn_q;
  logic [15:0] base_q [NUM_DEV];
  logic [15:0] base_sel;
  logic        idx_wr, dat_wr, dev_hit;

  assign idx_wr  = wr_i && !addr_i && mode_i;
  assign dat_wr  = wr_i && addr_i && mode_i;
  assign dev_hit = ldn_q < DEV_LIM;
  assign exit_o  = dat_wr && (index_q == IDX_CTRL) && (wdata_i == EXIT_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (idx_wr) index_q <= wdata_i;
      if (dat_wr && index_q == IDX_LDN) ldn_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic sel;
    assign sel = dat_wr && (ldn_q == 8'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g] <= '0;
      end else if (sel) begin
        if (index_q == IDX_BASE_HI) base_q[g][15:8] <= wdata_i;
        if (index_q == IDX_BASE_LO) base_q[g][7:0]  <= wdata_i;
      end
    end
  end

  assign base_sel = dev_hit ? base_q[ldn_q[DEV_W-1:0]] : 16'hFFFF;

  always_comb begin
    if (!mode_i)      rdata_o = RD_LOCKED;
    else if (!addr_i) rdata_o = index_q;
    else begin
      unique case (index_q)
        IDX_CTRL:    rdata_o = 8'h00;
        IDX_LDN:     rdata_o = ldn_q;
        IDX_ID_HI:   rdata_o = CHIP_ID[15:8];
        IDX_ID_LO:   rdata_o = CHIP_ID[7:0];
        IDX_REV:     rdata_o = {4'h0, CHIP_REV};
        IDX_BASE_HI: rdata_o = base_sel[15:8];
        IDX_BASE_LO: rdata_o = base_sel[7:0];
        default:     rdata_o = RD_LOCKED;
      endcase
    end
  end

  // R6
  locked_ldn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> $stable(ldn_q));

  // R6
  locked_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> $stable(index_q));

  // R11
  dev_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i && addr_i && index_q == IDX_BASE_LO && !dev_hit |-> rdata_o == 8'hFF);
endmodule

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock #(
  parameter int          NUM_DEV  = 4,
  parameter logic [15:0] CHIP_ID  = 16'hC0DE,
  parameter logic [3:0]  CHIP_REV = 4'h5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_alt_i,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       cfg_mode_o
);
  logic mode;
  logic exit_req;

  cfg_key_detect u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alt_i    (strap_alt_i),
    .idx_wr_i (wr_i && !addr_i),
    .wdata_i  (wdata_i),
    .exit_i   (exit_req),
    .mode_o   (mode)
  );

  cfg_regfile #(
    .NUM_DEV  (NUM_DEV),
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .exit_o  (exit_req)
  );

  assign cfg_mode_o = mode;

  // R1
  locked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_o |-> rdata_o == 8'hFF);
endmodule

// File: tb/cfg_key_unlock_test.sv
module cfg_key_unlock_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strap_alt_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       cfg_mode_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_key_unlock uut (
    .clk_i(clk), .rst_ni(rst_ni), .strap_alt_i(strap_alt_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .cfg_mode_o(cfg_mode_o)
  );

  // {req[3:0], op[1:0], data[7:0], expected[7:0]}
  // op 0 write index, 1 write data, 2 read index, 3 read data
  localparam int N = 47;
  localparam logic [21:0] TBL [N] = '{
    {4'd6, 2'd3, 8'h00, 8'hFF}, {4'd6, 2'd2, 8'h00, 8'hFF},              // R6
    {4'd2, 2'd0, 8'h87, 8'h00}, {4'd2, 2'd0, 8'h01, 8'h00},              // R2
    {4'd2, 2'd0, 8'h55, 8'h00}, {4'd2, 2'd0, 8'h55, 8'h00},
    {4'd11, 2'd2, 8'h00, 8'h00},                                         // R11
    {4'd7, 2'd0, 8'h20, 8'h00}, {4'd7, 2'd3, 8'h00, 8'hC0},              // R7
    {4'd7, 2'd0, 8'h21, 8'h00}, {4'd7, 2'd3, 8'h00, 8'hDE},
    {4'd7, 2'd1, 8'h11, 8'h00}, {4'd7, 2'd3, 8'h00, 8'hDE},
    {4'd8, 2'd0, 8'h22, 8'h00}, {4'd8, 2'd3, 8'h00, 8'h05},              // R8
    {4'd8, 2'd1, 8'hAB, 8'h00}, {4'd8, 2'd3, 8'h00, 8'h05},
    {4'd9, 2'd0, 8'h07, 8'h00}, {4'd9, 2'd1, 8'h01, 8'h00},              // R9
    {4'd9, 2'd3, 8'h00, 8'h01}, {4'd11, 2'd2, 8'h00, 8'h07},
    {4'd9, 2'd0, 8'h60, 8'h00}, {4'd9, 2'd1, 8'h12, 8'h00},
    {4'd9, 2'd0, 8'h61, 8'h00}, {4'd9, 2'd1, 8'h34, 8'h00},
    {4'd9, 2'd3, 8'h00, 8'h34}, {4'd9, 2'd0, 8'h60, 8'h00},
    {4'd9, 2'd3, 8'h00, 8'h12},
    {4'd9, 2'd0, 8'h07, 8'h00}, {4'd9, 2'd1, 8'h00, 8'h00},
    {4'd9, 2'd0, 8'h60, 8'h00}, {4'd9, 2'd3, 8'h00, 8'h00},
    {4'd11, 2'd0, 8'h07, 8'h00}, {4'd11, 2'd1, 8'h09, 8'h00},            // R11
    {4'd11, 2'd0, 8'h60, 8'h00}, {4'd11, 2'd1, 8'h55, 8'h00},
    {4'd11, 2'd3, 8'h00, 8'hFF},
    {4'd9, 2'd0, 8'h07, 8'h00}, {4'd9, 2'd1, 8'h01, 8'h00},
    {4'd9, 2'd0, 8'h60, 8'h00}, {4'd9, 2'd3, 8'h00, 8'h12},
    {4'd10, 2'd0, 8'h02, 8'h00}, {4'd10, 2'd1, 8'h05, 8'h00},            // R10
    {4'd10, 2'd3, 8'h00, 8'h00}, {4'd10, 2'd1, 8'h02, 8'h00},
    {4'd10, 2'd3, 8'h00, 8'hFF}, {4'd10, 2'd2, 8'h00, 8'hFF}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic key(input logic [7:0] last);
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, last);
  endtask

  task automatic leave();
    wr(1'b0, 8'h02); wr(1'b1, 8'h02);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    #1 check("R1 mode", {7'd0, cfg_mode_o}, 8'h00);
    rd(1'b1, v); check("R1 data", v, 8'hFF);
    rd(1'b0, v); check("R1 index", v, 8'hFF);

    for (int i = 0; i < N; i++) begin
      logic [3:0] rq;
      logic [1:0] op;
      rq = TBL[i][21:18];
      op = TBL[i][17:16];
      if (op[1] == 1'b0) wr(op[0], TBL[i][15:8]);
      else begin
        rd(op[0], v);
        check($sformatf("R%0d table %0d", rq, i), v, TBL[i][7:0]);
      end
    end

    // R6 locked writes leave select and index untouched
    wr(1'b0, 8'h07); wr(1'b1, 8'h03);
    #1 check("R6 still locked", {7'd0, cfg_mode_o}, 8'h00);
    key(8'h55);
    rd(1'b0, v); check("R6 index kept", v, 8'h02);
    wr(1'b0, 8'h07);
    rd(1'b1, v); check("R6 select kept", v, 8'h01);
    leave();

    // R5 stray 0xAA with primary strap
    key(8'hAA);
    #1 check("R5 AA no unlock", {7'd0, cfg_mode_o}, 8'h00);
    wr(1'b0, 8'hAA);
    key(8'h55);
    #1 check("R5 unlock after AA", {7'd0, cfg_mode_o}, 8'h01);
    leave();

    // R4 mismatch handling
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h02); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    #1 check("R4 broken key", {7'd0, cfg_mode_o}, 8'h00);
    wr(1'b0, 8'h87);
    key(8'h55);
    #1 check("R4 87 restart", {7'd0, cfg_mode_o}, 8'h01);
    leave();
    wr(1'b0, 8'h87); wr(1'b0, 8'h01);
    key(8'h55);
    #1 check("R4 87 mid restart", {7'd0, cfg_mode_o}, 8'h01);

    // R10 other control value keeps mode
    wr(1'b0, 8'h02); wr(1'b1, 8'h03);
    #1 check("R10 non-exit value", {7'd0, cfg_mode_o}, 8'h01);
    wr(1'b1, 8'h02);
    #1 check("R10 exit", {7'd0, cfg_mode_o}, 8'h00);

    // R12 reset clears mode and select
    key(8'h55);
    wr(1'b0, 8'h07); wr(1'b1, 8'h02);
    do_reset();
    #1 check("R12 mode cleared", {7'd0, cfg_mode_o}, 8'h00);
    key(8'h55);
    wr(1'b0, 8'h07);
    rd(1'b1, v); check("R12 select cleared", v, 8'h00);

    // R3 alternate strap
    @(negedge clk); rst_ni = 1'b0; strap_alt_i = 1'b1;
    repeat (2) @(negedge clk); rst_ni = 1'b1;
    key(8'h55);
    #1 check("R3 primary key rejected", {7'd0, cfg_mode_o}, 8'h00);
    key(8'hAA);
    #1 check("R3 alt key", {7'd0, cfg_mode_o}, 8'h01);
    wr(1'b0, 8'h20);
    rd(1'b1, v); check("R3 id after alt unlock", v, 8'hC0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule